// File: doc/BRIEF.md
# Masked Indexed Vector Load/Store Engine

This block moves data between a small on-block vector store and a word-addressed data memory, using an index vector instead of a stride to pick the memory words. A gather fills lane i of the data vector from the memory word named by lane i of the index vector. A scatter copies lane i of the data vector to the memory word named by lane i of the index vector. Only the lanes covered by the command length are visited, so a sparse operand is handled by listing only the positions of its nonzero entries in the index vector.

Each command carries a per-lane enable mask. A lane whose mask bit is clear makes no memory access and, for a gather, keeps its old data value. A caller can run a sequence of commands while clearing mask bits step by step, for example in a prefix computation where fewer lanes take part at each step. The engine visits one lane per clock in ascending lane order. The memory is synchronous and single-ported with a read latency of one cycle, so a gather overlaps the address for lane i+1 with the capture of lane i and needs one extra cycle to finish. A host port writes the data and index vectors while the engine is idle, and it can read them back at any time.

Top module: `gs_unit`

## Requirements
- R1: A gather (cmd_op = 0) sets data lane i to the memory word at address index[i] for every enabled lane i below the effective length.
- R2: A scatter (cmd_op = 1) writes data lane i to memory address index[i] for every enabled lane i below the effective length. When two enabled lanes hold the same index, the higher-numbered lane's value remains in memory.
- R3: A lane whose cmd_mask bit is 0, or whose number is at or above the effective length, makes no memory access (mem_en stays low in its cycle). A gather leaves that lane's data unchanged.
- R4: A start is accepted on a clock edge where busy is low. Lane k is presented in the (k+1)-th cycle after that edge, with mem_addr = index[k], mem_we = 1 for a scatter and 0 for a gather, and for a scatter mem_wdata = data[k].
- R5: A gather captures mem_rdata one cycle after it issues the address. The last lane's value is therefore written one cycle after its address, and a gather takes one cycle longer than a scatter.
- R6: busy is high from the cycle after an accepted start until done. done is high for exactly one cycle, with busy low: cycle eff_len+1 after the start edge for a scatter, and cycle eff_len+2 for a gather.
- R7: A command with length zero raises done in the first cycle after the start edge. busy does not rise and there is no memory access.
- R8: cmd_start is ignored while busy is high, so the running command's timing and operation do not change.
- R9: Host writes to the data or index vector (host_wr_data_en, host_wr_idx_en) are ignored while busy is high and take effect on the next edge while idle. host_rd_data and host_rd_idx show the selected lane combinationally.
- R10: After reset, busy, done and mem_en are low and every data and index lane reads zero.
- R11: A cmd_len above LANES is treated as LANES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start request, sampled while idle |
| cmd_op | input | 1 | 0 = gather, 1 = scatter |
| cmd_len | input | LEN_W | Number of lanes to visit, clamped to LANES |
| cmd_mask | input | LANES | Per-lane enable, bit i for lane i |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (scatter) when mem_en is high |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after a read |
| host_wr_data_en | input | 1 | Write host_wr_data into the data lane |
| host_wr_idx_en | input | 1 | Write host_wr_idx into the index lane |
| host_wr_lane | input | LANE_W | Lane selected for a host write |
| host_wr_data | input | DATA_W | Host data value |
| host_wr_idx | input | ADDR_W | Host index value |
| host_rd_lane | input | LANE_W | Lane selected for a host read |
| host_rd_data | output | DATA_W | Data value of the selected lane |
| host_rd_idx | output | ADDR_W | Index value of the selected lane |

## Verification
The bench counts cycles from the edge that accepts a start. It expects lane k's memory request in cycle k+1, done in cycle eff_len+1 for a scatter and eff_len+2 for a gather, and done low again one cycle later. It samples every output at the falling edge within each of those cycles. The vector contents and the memory image are read back only after done has been seen, because the last gather capture lands on the same edge that raises done.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } gs_state_e;

    typedef enum logic {
        OP_GATHER  = 1'b0,
        OP_SCATTER = 1'b1
    } gs_op_e;

endpackage

// File: rtl/gs_sequencer.sv
module gs_sequencer
    import gs_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = $clog2(LANES),
    parameter int LEN_W  = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_op,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [LANES-1:0]  cmd_mask,
    output logic              busy,
    output logic              done,
    output logic              issue_en,
    output logic              issue_scatter,
    output logic [LANE_W-1:0] issue_lane,
    output logic              cap_en,
    output logic [LANE_W-1:0] cap_lane
);

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(LANES);

    typedef struct packed {
        gs_state_e         state;
        gs_op_e            op;
        logic [LANE_W-1:0] el;
        logic [LANE_W-1:0] last;
        logic [LANES-1:0]  mask;
        logic              cap_vld;
        logic [LANE_W-1:0] cap_lane;
        logic              done;
    } seq_s;

    localparam seq_s SEQ_RST = '{
        state:    ST_IDLE,
        op:       OP_GATHER,
        el:       '0,
        last:     '0,
        mask:     '0,
        cap_vld:  1'b0,
        cap_lane: '0,
        done:     1'b0
    };

    seq_s seq_d, seq_q;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        eff_len = (cmd_len > MAX_LEN) ? MAX_LEN : cmd_len;
        seq_d = seq_q;
        seq_d.done = 1'b0;
        seq_d.cap_vld = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (cmd_start) begin
                    if (eff_len == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.state = ST_RUN;
                        seq_d.op    = gs_op_e'(cmd_op);
                        seq_d.el    = '0;
                        seq_d.last  = LANE_W'(eff_len - 1'b1);
                        seq_d.mask  = cmd_mask;
                    end
                end
            end
            ST_RUN: begin
                // a gathered word comes back one cycle after its address
                if (seq_q.op == OP_GATHER && seq_q.mask[seq_q.el]) begin
                    seq_d.cap_vld  = 1'b1;
                    seq_d.cap_lane = seq_q.el;
                end
                if (seq_q.el == seq_q.last) begin
                    if (seq_q.op == OP_GATHER) begin
                        seq_d.state = ST_DRAIN;
                    end else begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end
                end else begin
                    seq_d.el = seq_q.el + 1'b1;
                end
            end
            ST_DRAIN: begin
                seq_d.state = ST_IDLE;
                seq_d.done  = 1'b1;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign busy          = (seq_q.state != ST_IDLE);
    assign done          = seq_q.done;
    assign issue_en      = (seq_q.state == ST_RUN) && seq_q.mask[seq_q.el];
    assign issue_scatter = (seq_q.op == OP_SCATTER);
    assign issue_lane    = seq_q.el;
    assign cap_en        = seq_q.cap_vld;
    assign cap_lane      = seq_q.cap_lane;

endmodule

// File: rtl/gs_vec_store.sv
module gs_vec_store #(
    parameter int LANES  = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              cap_en,
    input  logic [LANE_W-1:0] cap_lane,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              host_wr_data_en,
    input  logic              host_wr_idx_en,
    input  logic [LANE_W-1:0] host_wr_lane,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic [ADDR_W-1:0] host_wr_idx,
    input  logic [LANE_W-1:0] eng_lane,
    output logic [DATA_W-1:0] eng_data,
    output logic [ADDR_W-1:0] eng_idx,
    input  logic [LANE_W-1:0] host_rd_lane,
    output logic [DATA_W-1:0] host_rd_data,
    output logic [ADDR_W-1:0] host_rd_idx
);

    logic [DATA_W-1:0] data_arr [LANES];
    logic [ADDR_W-1:0] idx_arr  [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DATA_W-1:0] data_d, data_q;
        logic [ADDR_W-1:0] idx_d,  idx_q;
        logic              host_hit;

        always_comb begin
            host_hit = !busy && (host_wr_lane == LANE_W'(l));
            data_d   = data_q;
            idx_d    = idx_q;
            if (cap_en && cap_lane == LANE_W'(l)) begin
                data_d = cap_data;
            end else if (host_hit && host_wr_data_en) begin
                data_d = host_wr_data;
            end
            if (host_hit && host_wr_idx_en) begin
                idx_d = host_wr_idx;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q <= '0;
                idx_q  <= '0;
            end else begin
                data_q <= data_d;
                idx_q  <= idx_d;
            end
        end

        assign data_arr[l] = data_q;
        assign idx_arr[l]  = idx_q;
    end

    assign eng_data     = data_arr[eng_lane];
    assign eng_idx      = idx_arr[eng_lane];
    assign host_rd_data = data_arr[host_rd_lane];
    assign host_rd_idx  = idx_arr[host_rd_lane];

endmodule

// File: rtl/gs_mem_req.sv
module gs_mem_req #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              issue_en,
    input  logic              issue_scatter,
    input  logic [ADDR_W-1:0] lane_idx,
    input  logic [DATA_W-1:0] lane_data,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    // hold the bus at zero in idle and masked cycles
    always_comb begin
        mem_en    = issue_en;
        mem_we    = issue_en && issue_scatter;
        mem_addr  = issue_en ? lane_idx : '0;
        mem_wdata = (issue_en && issue_scatter) ? lane_data : '0;
    end

endmodule

// File: rtl/gs_unit.sv
module gs_unit #(
    parameter int LANES  = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    // derived widths, left at their defaults
    parameter int LANE_W = $clog2(LANES),
    parameter int LEN_W  = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_op,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [LANES-1:0]  cmd_mask,
    output logic              busy,
    output logic              done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              host_wr_data_en,
    input  logic              host_wr_idx_en,
    input  logic [LANE_W-1:0] host_wr_lane,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic [ADDR_W-1:0] host_wr_idx,
    input  logic [LANE_W-1:0] host_rd_lane,
    output logic [DATA_W-1:0] host_rd_data,
    output logic [ADDR_W-1:0] host_rd_idx
);

    logic              issue_en;
    logic              issue_scatter;
    logic [LANE_W-1:0] issue_lane;
    logic              cap_en;
    logic [LANE_W-1:0] cap_lane;
    logic [DATA_W-1:0] eng_data;
    logic [ADDR_W-1:0] eng_idx;

    gs_sequencer #(
        .LANES (LANES),
        .LANE_W(LANE_W),
        .LEN_W (LEN_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_op       (cmd_op),
        .cmd_len      (cmd_len),
        .cmd_mask     (cmd_mask),
        .busy         (busy),
        .done         (done),
        .issue_en     (issue_en),
        .issue_scatter(issue_scatter),
        .issue_lane   (issue_lane),
        .cap_en       (cap_en),
        .cap_lane     (cap_lane)
    );

    gs_vec_store #(
        .LANES (LANES),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .LANE_W(LANE_W)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .busy           (busy),
        .cap_en         (cap_en),
        .cap_lane       (cap_lane),
        .cap_data       (mem_rdata),
        .host_wr_data_en(host_wr_data_en),
        .host_wr_idx_en (host_wr_idx_en),
        .host_wr_lane   (host_wr_lane),
        .host_wr_data   (host_wr_data),
        .host_wr_idx    (host_wr_idx),
        .eng_lane       (issue_lane),
        .eng_data       (eng_data),
        .eng_idx        (eng_idx),
        .host_rd_lane   (host_rd_lane),
        .host_rd_data   (host_rd_data),
        .host_rd_idx    (host_rd_idx)
    );

    gs_mem_req #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_mreq (
        .issue_en     (issue_en),
        .issue_scatter(issue_scatter),
        .lane_idx     (eng_idx),
        .lane_data    (eng_data),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata)
    );

endmodule

// File: rtl/gs_unit_chk.sv
module gs_unit_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic [LEN_W-1:0] cmd_len,
    input logic             busy,
    input logic             done,
    input logic             mem_en,
    input logic             mem_we
);

    // R7: an empty command completes at once without going busy
    a_r7_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy && cmd_len == '0) |=> (done && !busy));

    // R6: the done pulse arrives while idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: busy only drops together with done
    a_r6_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3: no memory traffic outside a command
    a_r3_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R8: the direction of a running command never changes
    a_r8_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && mem_en && $past(mem_en)) |-> (mem_we == $past(mem_we)));

endmodule

bind gs_unit gs_unit_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_start(cmd_start),
    .cmd_len  (cmd_len),
    .busy     (busy),
    .done     (done),
    .mem_en   (mem_en),
    .mem_we   (mem_we)
);

// File: tb/tb_gs_unit.sv
module tb_gs_unit;

    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 8;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 6;
    localparam int LANE_W = 3;
    localparam int LEN_W  = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start = 1'b0;
    logic              cmd_op = 1'b0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [LANES-1:0]  cmd_mask = '0;
    logic              busy, done, mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              host_wr_data_en = 1'b0;
    logic              host_wr_idx_en = 1'b0;
    logic [LANE_W-1:0] host_wr_lane = '0;
    logic [DATA_W-1:0] host_wr_data = '0;
    logic [ADDR_W-1:0] host_wr_idx = '0;
    logic [LANE_W-1:0] host_rd_lane = '0;
    logic [DATA_W-1:0] host_rd_data;
    logic [ADDR_W-1:0] host_rd_idx;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DATA_W-1:0] mem     [DEPTH];
    logic [DATA_W-1:0] ref_mem [DEPTH];
    logic [DATA_W-1:0] ref_data[LANES];
    logic [ADDR_W-1:0] ref_idx [LANES];

    always #(CLK_PERIOD / 2) clk = ~clk;

    gs_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_start      (cmd_start),
        .cmd_op         (cmd_op),
        .cmd_len        (cmd_len),
        .cmd_mask       (cmd_mask),
        .busy           (busy),
        .done           (done),
        .mem_en         (mem_en),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_rdata      (mem_rdata),
        .host_wr_data_en(host_wr_data_en),
        .host_wr_idx_en (host_wr_idx_en),
        .host_wr_lane   (host_wr_lane),
        .host_wr_data   (host_wr_data),
        .host_wr_idx    (host_wr_idx),
        .host_rd_lane   (host_rd_lane),
        .host_rd_data   (host_rd_data),
        .host_rd_idx    (host_rd_idx)
    );

    // synchronous single-port memory, one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= DATA_W'(a * 37 + 5);
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int l = 0; l < LANES; l++) begin
            host_rd_lane = LANE_W'(l);
            #1;
            chk(req, $sformatf("data lane %0d", l), 32'(host_rd_data), 32'(ref_data[l]));
            chk("R9", $sformatf("idx lane %0d", l), 32'(host_rd_idx), 32'(ref_idx[l]));
        end
        for (int a = 0; a < DEPTH; a++) begin
            chk(req, $sformatf("mem word %0d", a), 32'(mem[a]), 32'(ref_mem[a]));
        end
    endtask

    task automatic write_lane(input int l, input logic [DATA_W-1:0] d, input logic [ADDR_W-1:0] ix);
        @(negedge clk);
        host_wr_data_en = 1'b1;
        host_wr_idx_en  = 1'b1;
        host_wr_lane    = LANE_W'(l);
        host_wr_data    = d;
        host_wr_idx     = ix;
        @(negedge clk);
        host_wr_data_en = 1'b0;
        host_wr_idx_en  = 1'b0;
        ref_data[l] = d;
        ref_idx[l]  = ix;
    endtask

    // cycle-by-cycle expectation of one command, then the end state
    task automatic run_cmd(input string req, input logic op, input int len,
                           input logic [LANES-1:0] mask, input bit inject);
        int eff = (len > LANES) ? LANES : len;
        int fin = (eff == 0) ? 0 : (op ? eff : eff + 1);
        bit exp_en;
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_op    = op;
        cmd_len   = LEN_W'(len);
        cmd_mask  = mask;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 0; k <= fin; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 2) begin
                cmd_start = 1'b0;
                host_wr_data_en = 1'b0;
            end
            exp_en = (k < eff) && mask[k];
            chk("R6", $sformatf("%s busy cycle %0d", req, k), 32'(busy), 32'(k < fin));
            chk("R6", $sformatf("%s done cycle %0d", req, k), 32'(done), 32'(k == fin));
            chk("R3", $sformatf("%s mem_en cycle %0d", req, k), 32'(mem_en), 32'(exp_en));
            if (exp_en) begin
                chk("R4", $sformatf("%s mem_we lane %0d", req, k), 32'(mem_we), 32'(op));
                chk("R4", $sformatf("%s mem_addr lane %0d", req, k), 32'(mem_addr), 32'(ref_idx[k]));
                if (op) chk("R2", $sformatf("%s wdata lane %0d", req, k), 32'(mem_wdata), 32'(ref_data[k]));
            end
            if (inject && k == 1) begin
                // R8 and R9 stimulus while busy
                cmd_start       = 1'b1;
                cmd_op          = ~op;
                cmd_len         = '0;
                host_wr_data_en = 1'b1;
                host_wr_lane    = 3'd2;
                host_wr_data    = 16'hDEAD;
            end
        end
        for (int i = 0; i < eff; i++) begin
            if (mask[i]) begin
                if (op) ref_mem[ref_idx[i]] = ref_data[i];
                else    ref_data[i] = ref_mem[ref_idx[i]];
            end
        end
        @(negedge clk);
        chk("R6", $sformatf("%s done pulse ends", req), 32'(done), 32'd0);
        check_all(req);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = DATA_W'(a * 37 + 5);
        for (int l = 0; l < LANES; l++) begin
            ref_data[l] = '0;
            ref_idx[l]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10", "busy", 32'(busy), 32'd0);
        chk("R10", "done", 32'(done), 32'd0);
        chk("R10", "mem_en", 32'(mem_en), 32'd0);
        check_all("R10");

        // R9 idle host writes; duplicate index 17 on lanes 4 and 5
        write_lane(0, 16'd100, 6'd3);
        write_lane(1, 16'd101, 6'd10);
        write_lane(2, 16'd102, 6'd63);
        write_lane(3, 16'd103, 6'd0);
        write_lane(4, 16'd104, 6'd17);
        write_lane(5, 16'd105, 6'd17);
        write_lane(6, 16'd106, 6'd42);
        write_lane(7, 16'd107, 6'd5);
        check_all("R9");

        // R1 full gather, R5 drain timing
        run_cmd("R1", 1'b0, 8, 8'hFF, 1'b0);

        // R3 masked and out-of-length lanes keep their data
        for (int l = 0; l < LANES; l++) write_lane(l, DATA_W'(16'h1000 + l), ref_idx[l]);
        run_cmd("R3", 1'b0, 5, 8'b0001_0110, 1'b0);

        // R2 scatter, higher lane wins on equal index
        for (int l = 0; l < LANES; l++) write_lane(l, DATA_W'(16'hA000 + l), ref_idx[l]);
        run_cmd("R2", 1'b1, 8, 8'hFF, 1'b0);
        chk("R2", "lane5 wins at 17", 32'(mem[17]), 32'h0000A005);

        // R2 with lane 5 masked, lane 4 now remains
        for (int l = 0; l < LANES; l++) write_lane(l, DATA_W'(16'hB000 + l), ref_idx[l]);
        run_cmd("R2", 1'b1, 8, 8'hDF, 1'b0);
        chk("R2", "lane4 value at 17", 32'(mem[17]), 32'h0000B004);

        // R7 zero length, both directions
        run_cmd("R7", 1'b0, 0, 8'hFF, 1'b0);
        run_cmd("R7", 1'b1, 0, 8'hFF, 1'b0);

        // R11 oversize length clamps to LANES
        for (int l = 0; l < LANES; l++) write_lane(l, DATA_W'(16'hC000 + l), ref_idx[l]);
        run_cmd("R11", 1'b1, 12, 8'hFF, 1'b0);

        // R8 start and R9 host write ignored while busy
        for (int l = 0; l < LANES; l++) write_lane(l, DATA_W'(16'hD000 + l), DATA_W'(l * 7 + 1) >> 0);
        run_cmd("R8", 1'b1, 8, 8'hFF, 1'b1);
        chk("R9", "lane2 not overwritten", 32'(ref_data[2]), 32'h0000D002);

        // R3 shrinking masks step by step
        for (int s = 0; s < 4; s++) begin
            run_cmd("R3", 1'b0, 8, 8'hFF << s, 1'b0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule